// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block gathers up to 64 interrupt request lines for one processor. Each line keeps two pending records: a raw record that captures every request whether or not the line is enabled, and a status record that holds only the requests of enabled lines. If a line is enabled later while its raw bit is set, the request becomes visible at that point. Each line carries an 8-bit priority, where a lower value is more urgent. The block also holds the priority of the handler now running. From these values a combinational arbiter names the most urgent pending line that outranks the running handler.

Software drives register-style strobes. These enable and disable lines, clear pending bits one at a time or in bulk, write priorities, write the running priority, and set or release a global lock. The lock keeps all requests on record but holds back the wake pulse and the winner until it is released. A one-shot bypass request lets the next hardware request wake the processor despite the lock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every line is disabled, both pending records are zero, the lock is off, every line priority is 255 and the running priority is 256, meaning no handler is active. `wake` is 0 and `win_valid` is 0.
- R2: A high bit of `raise_vec` sets the line's raw bit in the next cycle. It sets the status bit only if the line is enabled after that cycle's enable and disable strobes. While the lock is off, any raise gives a one-cycle `wake` pulse in the next cycle, even for a disabled line.
- R3: Enabling a line whose raw bit is set sets its status bit in the next cycle and, while unlocked, gives a `wake` pulse in that cycle.
- R4: While the lock is set, requests are still recorded in both records, but `wake` stays 0 and `win_valid` stays 0.
- R5: A lock write that changes the lock from set to clear while any status bit is set gives a `wake` pulse in the next cycle.
- R6: `win_valid` is 1 when the lock is off and some status line has a priority value strictly below the running priority. `win_idx` is then the binary line number of the line with the smallest priority value among them. A running priority of 256 lets any pending line win, including one at priority 255.
- R7: When several status lines share the best priority value, the lowest-numbered line wins.
- R8: `clr_enabled_all` zeroes the status record and clears only the raw bits of currently enabled lines. `clr_all` zeroes both records and takes precedence over `clr_enabled_all`.
- R9: A bit of `pend_clr` clears that line's raw and status bits. A raise of the same line in the same cycle takes precedence, and both bits end up set.
- R10: A `bypass_req` pulse arms a flag that lets the next hardware raise wake the processor while locked. The first hardware raise uses up the flag, so a later raise under the lock does not wake.
- R11: Disabling a line leaves its status bit unchanged. When `en_set` and `en_clr` hit the same line in one cycle, the line ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_vec | input | 64 | Hardware request pulses, one bit per line |
| bypass_req | input | 1 | Arms the one-shot lock bypass for the next hardware raise |
| en_set | input | 64 | Enable strobes per line |
| en_clr | input | 64 | Disable strobes per line; override `en_set` |
| pend_clr | input | 64 | Per-line clear of raw and status bits |
| clr_enabled_all | input | 1 | Clear the status record and the raw bits of enabled lines |
| clr_all | input | 1 | Clear both records |
| prio_wr | input | 1 | Write strobe for one line priority |
| prio_idx | input | 6 | Line number for the priority write |
| prio_val | input | 8 | Priority value to write (0 most urgent) |
| run_wr | input | 1 | Write strobe for the running priority |
| run_val | input | 9 | Running priority; 256 means none active |
| lock_wr | input | 1 | Write strobe for the global lock |
| lock_val | input | 1 | New lock value |
| wake | output | 1 | One-cycle interrupt and wake pulse |
| win_valid | output | 1 | A winning line exists |
| win_idx | output | 6 | Binary number of the winning line |
| pend_status | output | 64 | Status record, visible to the processor |
| pend_raw | output | 64 | Raw record, kept before the mask |

## Verification
On every cycle, the embedded assertions check that the status record stays a subset of the raw record. They also check that the winner is a pending line whose priority beats the running priority, that no winner appears while the lock is held, and that the bypass flag is spent by any hardware raise. The bench scenarios cover the things a single-cycle property cannot see. These are the cause and effect of the wake pulse under lock, unlock and bypass, the deferred visibility of a request when its line is enabled later, the two bulk clears with their different reach, and the tie and threshold outcomes of arbitration over chosen priority patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int NUM_LINES = 64;
    parameter int PRIO_W    = 8;
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int RUN_W    = PRIO_W + 1;
    localparam logic [PRIO_W-1:0] PRIO_LOWEST = {PRIO_W{1'b1}};
    localparam logic [RUN_W-1:0]  RUN_IDLE    = RUN_W'(1) << PRIO_W;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } arb_node_t;

    // pick between a lower-numbered (a) and higher-numbered (b) candidate
    function automatic arb_node_t arb_pick(arb_node_t a, arb_node_t b);
        if (b.vld && (!a.vld || (b.prio < a.prio)))
            return b;
        return a;
    endfunction
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raise_vec,
    input  logic         bypass_req,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic [N-1:0] pend_clr,
    input  logic         clr_enabled_all,
    input  logic         clr_all,
    input  logic         lock_wr,
    input  logic         lock_val,
    output logic [N-1:0] status_q,
    output logic [N-1:0] raw_q,
    output logic         lock_q,
    output logic         wake_q
);
    logic [N-1:0] mask_q, mask_nx, newly_on, raw_nx, status_nx;
    logic         lock_nx, bypass_q, bypass_nx, bypass_eff, hw_any;
    logic         wake_hw, wake_en, wake_unlock, wake_nx;

    always_comb begin
        mask_nx  = (mask_q | en_set) & ~en_clr;
        newly_on = mask_nx & ~mask_q;

        raw_nx    = raw_q;
        status_nx = status_q;
        if (clr_all) begin
            raw_nx    = '0;
            status_nx = '0;
        end else if (clr_enabled_all) begin
            raw_nx    = raw_q & ~mask_q;
            status_nx = '0;
        end
        raw_nx    = raw_nx & ~pend_clr;
        status_nx = status_nx & ~pend_clr;
        raw_nx    = raw_nx | raise_vec;
        status_nx = status_nx | (raise_vec & mask_nx) | (newly_on & raw_nx);

        lock_nx    = lock_wr ? lock_val : lock_q;
        hw_any     = |raise_vec;
        bypass_eff = bypass_q | bypass_req;
        bypass_nx  = bypass_eff & ~hw_any;

        wake_hw     = hw_any & (~lock_q | bypass_eff);
        wake_en     = (|(newly_on & raw_nx)) & ~lock_q;
        wake_unlock = lock_q & ~lock_nx & (|status_nx);
        wake_nx     = wake_hw | wake_en | wake_unlock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            raw_q    <= '0;
            status_q <= '0;
            lock_q   <= 1'b0;
            bypass_q <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            mask_q   <= mask_nx;
            raw_q    <= raw_nx;
            status_q <= status_nx;
            lock_q   <= lock_nx;
            bypass_q <= bypass_nx;
            wake_q   <= wake_nx;
        end
    end

    AST_STATUS_IN_RAW: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~raw_q) == '0);                                  // R2
    AST_BYPASS_SPENT: assert property (@(posedge clk) disable iff (rst)
        (|raise_vec) |=> !bypass_q);                                 // R10
    AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lock_q && lock_nx && !bypass_eff) |=> !wake_q);             // R4
endmodule

// File: rtl/irqc_prio_regs.sv
module irqc_prio_regs
    import irqc_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prio_wr,
    input  logic [IDX_W-1:0]  prio_idx,
    input  logic [PRIO_W-1:0] prio_val,
    input  logic              run_wr,
    input  logic [RUN_W-1:0]  run_val,
    output logic [PRIO_W-1:0] prio_q [N],
    output logic [RUN_W-1:0]  run_q
);
    for (genvar i = 0; i < N; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= PRIO_LOWEST;
            else if (prio_wr && (prio_idx == IDX_W'(i)))
                prio_q[i] <= prio_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= RUN_IDLE;
        else if (run_wr)
            run_q <= run_val;
    end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0]      req,
    input  logic [PRIO_W-1:0] prio [N],
    input  logic [RUN_W-1:0]  run_prio,
    input  logic              locked,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);
    localparam int LVL    = (N > 1) ? $clog2(N) : 1;
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    arb_node_t tree [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign tree[LEAVES-1+i] = '{vld: req[i], prio: prio[i], idx: IDX_W'(i)};
        end else begin : g_pad
            assign tree[LEAVES-1+i] = '0;
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign tree[k] = arb_pick(tree[2*k+1], tree[2*k+2]);
    end

    assign win_valid = tree[0].vld && !locked && ({1'b0, tree[0].prio} < run_prio);
    assign win_idx   = tree[0].idx;
    assign win_prio  = tree[0].prio;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] raise_vec,
    input  logic                 bypass_req,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pend_clr,
    input  logic                 clr_enabled_all,
    input  logic                 clr_all,
    input  logic                 prio_wr,
    input  logic [IDX_W-1:0]     prio_idx,
    input  logic [PRIO_W-1:0]    prio_val,
    input  logic                 run_wr,
    input  logic [RUN_W-1:0]     run_val,
    input  logic                 lock_wr,
    input  logic                 lock_val,
    output logic                 wake,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output logic [NUM_LINES-1:0] pend_status,
    output logic [NUM_LINES-1:0] pend_raw
);
    logic              lock_q;
    logic [PRIO_W-1:0] prio_q [NUM_LINES];
    logic [RUN_W-1:0]  run_q;
    logic [PRIO_W-1:0] win_prio;

    irqc_pend #(.N(NUM_LINES)) u_pend (
        .clk(clk), .rst(rst),
        .raise_vec(raise_vec), .bypass_req(bypass_req),
        .en_set(en_set), .en_clr(en_clr), .pend_clr(pend_clr),
        .clr_enabled_all(clr_enabled_all), .clr_all(clr_all),
        .lock_wr(lock_wr), .lock_val(lock_val),
        .status_q(pend_status), .raw_q(pend_raw),
        .lock_q(lock_q), .wake_q(wake)
    );

    irqc_prio_regs #(.N(NUM_LINES)) u_prio (
        .clk(clk), .rst(rst),
        .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
        .run_wr(run_wr), .run_val(run_val),
        .prio_q(prio_q), .run_q(run_q)
    );

    irqc_arb #(.N(NUM_LINES)) u_arb (
        .req(pend_status), .prio(prio_q), .run_prio(run_q), .locked(lock_q),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    AST_LOCK_NO_WINNER: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !win_valid);                                      // R4
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> pend_status[win_idx]);                         // R6
    AST_WINNER_BEATS_RUN: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> ({1'b0, prio_q[win_idx]} < run_q));            // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!wake && pend_raw == '0 && !win_valid));     // R1
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    import irqc_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic [63:0] raise_vec, en_set, en_clr, pend_clr;
    logic bypass_req, clr_enabled_all, clr_all, prio_wr, run_wr, lock_wr, lock_val;
    logic [5:0] prio_idx;
    logic [7:0] prio_val;
    logic [8:0] run_val;
    logic wake, win_valid;
    logic [5:0] win_idx;
    logic [63:0] pend_status, pend_raw;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .raise_vec(raise_vec), .bypass_req(bypass_req),
        .en_set(en_set), .en_clr(en_clr), .pend_clr(pend_clr),
        .clr_enabled_all(clr_enabled_all), .clr_all(clr_all),
        .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
        .run_wr(run_wr), .run_val(run_val), .lock_wr(lock_wr), .lock_val(lock_val),
        .wake(wake), .win_valid(win_valid), .win_idx(win_idx),
        .pend_status(pend_status), .pend_raw(pend_raw)
    );

    // {line_a, prio_a, line_b, prio_b, running, exp_valid, exp_idx}
    localparam int NV = 8;
    localparam logic [43:0] VECS [NV] = '{
        {6'd3,  8'd10,  6'd7,  8'd5,   9'd256, 1'b1, 6'd7},
        {6'd3,  8'd5,   6'd7,  8'd5,   9'd256, 1'b1, 6'd3},
        {6'd40, 8'd20,  6'd2,  8'd20,  9'd256, 1'b1, 6'd2},
        {6'd10, 8'd8,   6'd20, 8'd9,   9'd8,   1'b0, 6'd0},
        {6'd10, 8'd8,   6'd20, 8'd9,   9'd9,   1'b1, 6'd10},
        {6'd63, 8'd0,   6'd0,  8'd1,   9'd256, 1'b1, 6'd63},
        {6'd0,  8'd255, 6'd1,  8'd255, 9'd255, 1'b0, 6'd0},
        {6'd0,  8'd255, 6'd63, 8'd255, 9'd256, 1'b1, 6'd0}
    };

    task automatic idle();
        raise_vec = '0; en_set = '0; en_clr = '0; pend_clr = '0;
        bypass_req = 0; clr_enabled_all = 0; clr_all = 0;
        prio_wr = 0; prio_idx = '0; prio_val = '0;
        run_wr = 0; run_val = '0; lock_wr = 0; lock_val = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        idle();
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 wake", 64'(wake), 0);
        chk("R1 status", pend_status, 0);
        chk("R1 raw", pend_raw, 0);
        chk("R1 win_valid", 64'(win_valid), 0);

        // R2 raise on disabled line
        raise_vec = 64'd1 << 5; cyc();
        chk("R2 raw bit", pend_raw, 64'd1 << 5);
        chk("R2 status untouched", pend_status, 0);
        chk("R2 wake pulse", 64'(wake), 1);
        cyc();
        chk("R2 wake one cycle", 64'(wake), 0);

        // R3 late enable; R1 default prio 255 beats idle 256
        en_set = 64'd1 << 5; cyc();
        chk("R3 status", pend_status, 64'd1 << 5);
        chk("R3 wake", 64'(wake), 1);
        chk("R1 default prio winner", {57'd0, win_valid, win_idx}, {57'd0, 1'b1, 6'd5});

        // R8 bulk clears
        raise_vec = 64'd1 << 6; cyc();
        clr_enabled_all = 1; cyc();
        chk("R8 enabled clear status", pend_status, 0);
        chk("R8 enabled clear raw", pend_raw, 64'd1 << 6);
        clr_all = 1; clr_enabled_all = 1; cyc();
        chk("R8 clear all raw", pend_raw, 0);

        // R4 lock
        lock_wr = 1; lock_val = 1; cyc();
        en_set = 64'd1 << 12; cyc();
        raise_vec = 64'd1 << 12; cyc();
        chk("R4 status recorded", pend_status, 64'd1 << 12);
        chk("R4 no wake", 64'(wake), 0);
        chk("R4 no winner", 64'(win_valid), 0);

        // R5 unlock
        lock_wr = 1; lock_val = 0; cyc();
        chk("R5 unlock wake", 64'(wake), 1);
        chk("R5 winner", {57'd0, win_valid, win_idx}, {57'd0, 1'b1, 6'd12});

        // R10 bypass
        lock_wr = 1; lock_val = 1; cyc();
        bypass_req = 1; cyc();
        chk("R10 arm no wake", 64'(wake), 0);
        raise_vec = 64'd1 << 13; cyc();
        chk("R10 bypass wake", 64'(wake), 1);
        raise_vec = 64'd1 << 14; cyc();
        chk("R10 flag spent", 64'(wake), 0);
        chk("R10 raw kept", pend_raw, (64'd1 << 12) | (64'd1 << 13) | (64'd1 << 14));
        lock_wr = 1; lock_val = 0; clr_all = 1; cyc();

        // R9 single clear and precedence
        en_set = 64'd1 << 20; cyc();
        raise_vec = 64'd1 << 20; cyc();
        pend_clr = 64'd1 << 20; cyc();
        chk("R9 clear both", pend_raw | pend_status, 0);
        pend_clr = 64'd1 << 20; raise_vec = 64'd1 << 20; cyc();
        chk("R9 raise wins raw", pend_raw, 64'd1 << 20);
        chk("R9 raise wins status", pend_status, 64'd1 << 20);

        // R11 disable keeps status; disable beats enable
        raise_vec = 64'd1 << 30; cyc();
        en_set = 64'd1 << 30; en_clr = (64'd1 << 30) | (64'd1 << 20); cyc();
        chk("R11 disable wins", pend_status, 64'd1 << 20);
        raise_vec = 64'd1 << 30; cyc();
        chk("R11 line stays off", pend_status, 64'd1 << 20);

        // R6 R7 arbitration table
        for (int v = 0; v < NV; v++) begin
            logic [5:0] la, lb, ei;
            logic [7:0] pa, pb;
            logic [8:0] rn;
            logic ev;
            {la, pa, lb, pb, rn, ev, ei} = VECS[v];
            clr_all = 1; en_clr = '1; cyc();
            prio_wr = 1; prio_idx = la; prio_val = pa; cyc();
            prio_wr = 1; prio_idx = lb; prio_val = pb; cyc();
            run_wr = 1; run_val = rn; cyc();
            en_set = (64'd1 << la) | (64'd1 << lb);
            raise_vec = en_set; cyc();
            chk("R6 R7 table winner", {57'd0, win_valid, (ev ? win_idx : 6'd0)},
                {57'd0, ev, ei});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule